// File: doc/BRIEF.md
# Iterative Floating-Point Remainder Unit

This unit takes two single-precision binary floating-point operands, a numerator and a divisor, and returns the exact remainder of the numerator by the divisor with the implied quotient truncated toward zero. The result has the magnitude `|n| - k*|d|` for the largest integer `k` that keeps it non-negative, and it carries the numerator's sign. Because that value is always representable, the unit needs no rounding and no quotient register.

Operands enter on a valid/ready stream. `in_ready` is high only while the unit is idle. One operand pair is taken on a cycle where `in_valid` and `in_ready` are both high. Special operands are settled on the accepting edge. Finite pairs are converted to a significand with a leading one and a signed exponent. A shift-subtract loop then removes one numerator bit position per cycle while the numerator exponent is above the divisor exponent. One equal-exponent correction follows, and the remainder is renormalized and repacked, as a subnormal where needed. The result is held on `res_o` with `out_valid` high until the consumer raises `out_ready`. Back-pressure on the output therefore stalls the unit, and no new operands are taken until the result has been accepted.

Top module: `fp_remainder`

## Requirements
- R1: If either operand is a NaN, the numerator is infinite, or the divisor is a zero of either sign, the result is the canonical quiet NaN 0x7FC00000 (sign 0, exponent field all ones, fraction MSB set).
- R2: If the divisor is infinite (and the numerator finite) or the numerator is a zero, the result is the numerator's 32-bit pattern unchanged.
- R3: For finite nonzero operands where the numerator magnitude is smaller than the divisor magnitude, the result is the numerator's bit pattern unchanged.
- R4: For other finite nonzero operands with normal encodings, the result equals exactly n - trunc(n/d)*d. Its sign bit (bit 31) is copied from the numerator, and a zero remainder is a zero with the numerator's sign.
- R5: Subnormal operands (exponent field 0, bits 30:23) are handled exactly, and a remainder below the smallest normal magnitude is encoded as a subnormal.
- R6: `in_ready` is high exactly when the unit is idle. A pair is accepted only on a cycle with `in_valid` and `in_ready` both high, and `in_valid` while busy has no effect on the pending result.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `res_o` is unchanged. The cycle after `out_valid` and `out_ready` are both high, `in_ready` is high again.
- R8: From acceptance to `out_valid`, the unit takes at most 280 clock cycles for any operand pair.
- R9: After reset, `in_ready` is high and `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand pair present on `num_i`/`den_i` |
| in_ready | output | 1 | Unit idle and able to take a pair |
| num_i | input | 32 | Numerator, single-precision encoding |
| den_i | input | 32 | Divisor, single-precision encoding |
| out_valid | output | 1 | Result present on `res_o` |
| out_ready | input | 1 | Consumer takes the result |
| res_o | output | 32 | Remainder, single-precision encoding |

## Verification
The hardest situation to reach is a long loop whose remainder leaves the normal range. The loop must run close to its full exponent span and still end with a remainder that has to be repacked as a subnormal. To reach it, the stimulus pairs the largest finite value and large powers of two with the smallest subnormals and with subnormal divisors whose fractions are odd. It then adds a dense sweep in which both operands are subnormal. A separate scenario raises `in_valid` with different operands during the longest loop, and another holds `out_ready` low, so that operand blocking and result holding are observed at the ports.

// File: rtl/fprem_pkg.sv
package fprem_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } fprem_state_e;

  typedef struct packed {
    logic nan;
    logic inf;
    logic zero;
  } fprem_class_t;

endpackage

// File: rtl/fprem_lzc.sv
module fprem_lzc #(
  parameter int N = 24,
  localparam int CW = $clog2(N + 1)
) (
  input  logic [N-1:0]  vec_i,
  output logic [CW-1:0] cnt_o
);

  logic hit;

  always_comb begin
    hit   = 1'b0;
    cnt_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!hit) begin
        if (vec_i[i]) hit = 1'b1;
        else          cnt_o = cnt_o + 1'b1;
      end
    end
  end

endmodule

// File: rtl/fprem_unpack.sv
module fprem_unpack #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int W     = 1 + EXP_W + MAN_W,
  localparam int SIG_W = MAN_W + 1,
  localparam int SW    = SIG_W + 1,
  localparam int XW    = EXP_W + 2
) (
  input  logic [W-1:0]             op_i,
  output logic                     sign_o,
  output fprem_pkg::fprem_class_t  cls_o,
  output logic [SW-1:0]            sig_o,
  output logic signed [XW-1:0]     exp_o
);

  localparam int BIAS = (1 << (EXP_W - 1)) - 1;
  localparam int LZW  = $clog2(SIG_W + 1);
  localparam logic signed [XW-1:0] EMIN = XW'(1 - BIAS);

  logic [EXP_W-1:0] efield;
  logic [MAN_W-1:0] frac;
  logic [SIG_W-1:0] raw;
  logic [SIG_W-1:0] norm;
  logic [LZW-1:0]   lz;

  assign efield = op_i[W-2 -: EXP_W];
  assign frac   = op_i[MAN_W-1:0];
  assign sign_o = op_i[W-1];
  assign raw    = {1'b0, frac};

  fprem_lzc #(.N(SIG_W)) u_lzc (
    .vec_i (raw),
    .cnt_o (lz)
  );

  assign norm = raw << lz;

  always_comb begin
    cls_o.nan  = (efield == '1) && (frac != '0);
    cls_o.inf  = (efield == '1) && (frac == '0);
    cls_o.zero = (efield == '0) && (frac == '0);
    if (efield == '0) begin
      // subnormal: move the leading one up, lower the exponent to match
      sig_o = {1'b0, norm};
      exp_o = EMIN - $signed({{(XW - LZW){1'b0}}, lz});
    end else begin
      sig_o = {2'b01, frac};
      exp_o = $signed({2'b00, efield}) - $signed(XW'(BIAS));
    end
  end

endmodule

// File: rtl/fprem_pack.sv
module fprem_pack #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int W     = 1 + EXP_W + MAN_W,
  localparam int SIG_W = MAN_W + 1,
  localparam int XW    = EXP_W + 2
) (
  input  logic                 sign_i,
  input  logic [SIG_W-1:0]     mag_i,
  input  logic signed [XW-1:0] exp_i,
  output logic [W-1:0]         word_o
);

  localparam int BIAS = (1 << (EXP_W - 1)) - 1;
  localparam int LZW  = $clog2(SIG_W + 1);
  localparam logic signed [XW-1:0] EMIN = XW'(1 - BIAS);

  logic [LZW-1:0]          lz;
  logic [SIG_W-1:0]        m;
  logic [SIG_W-1:0]        sub;
  logic signed [XW-1:0]    e;
  logic signed [XW-1:0]    ebias;
  logic [XW-1:0]           sh;

  fprem_lzc #(.N(SIG_W)) u_lzc (
    .vec_i (mag_i),
    .cnt_o (lz)
  );

  assign m     = mag_i << lz;
  assign e     = exp_i - $signed({{(XW - LZW){1'b0}}, lz});
  assign ebias = e + $signed(XW'(BIAS));
  assign sh    = EMIN - e;
  assign sub   = m >> sh;

  always_comb begin
    if (mag_i == '0) begin
      word_o = {sign_i, {(W - 1){1'b0}}};
    end else if (e >= EMIN) begin
      word_o = {sign_i, ebias[EXP_W-1:0], m[MAN_W-1:0]};
    end else begin
      // below the normal range: denormalize; shifted-out bits are zero
      word_o = {sign_i, {EXP_W{1'b0}}, sub[MAN_W-1:0]};
    end
  end

endmodule

// File: rtl/fp_remainder.sv
module fp_remainder #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int W = 1 + EXP_W + MAN_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] num_i,
  input  logic [W-1:0] den_i,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] res_o
);

  import fprem_pkg::*;

  localparam int SIG_W   = MAN_W + 1;
  localparam int SW      = SIG_W + 1;
  localparam int XW      = EXP_W + 2;
  localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
  localparam int MAX_RUN = 2 * BIAS + MAN_W;
  localparam int CNT_W   = $clog2(MAX_RUN + 2);
  localparam logic [W-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W - 1){1'b0}}};

  fprem_state_e         state_q;
  logic                 sign_q;
  logic [SW-1:0]        ns_q, ds_q;
  logic signed [XW-1:0] ne_q, de_q;
  logic [W-1:0]         res_q;

  fprem_class_t         n_cls, d_cls;
  logic                 n_sign, d_sign;
  logic [SW-1:0]        n_sig, d_sig;
  logic signed [XW-1:0] n_exp, d_exp;

  fprem_unpack #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_unp_num (
    .op_i (num_i), .sign_o (n_sign), .cls_o (n_cls), .sig_o (n_sig), .exp_o (n_exp)
  );

  fprem_unpack #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_unp_den (
    .op_i (den_i), .sign_o (d_sign), .cls_o (d_cls), .sig_o (d_sig), .exp_o (d_exp)
  );

  logic          nan_case, pass_case;
  logic          step_go, sub_ok;
  logic [SW-1:0] diff, fin;
  logic [W-1:0]  packed_w;

  assign nan_case  = n_cls.nan | d_cls.nan | n_cls.inf | d_cls.zero;
  assign pass_case = d_cls.inf | n_cls.zero;

  assign step_go = (ne_q > de_q) && (ns_q != '0);
  assign sub_ok  = ns_q >= ds_q;
  assign diff    = sub_ok ? (ns_q - ds_q) : ns_q;
  assign fin     = ((ne_q == de_q) && sub_ok) ? (ns_q - ds_q) : ns_q;

  fprem_pack #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_pack (
    .sign_i (sign_q),
    .mag_i  (fin[SIG_W-1:0]),
    .exp_i  (ne_q),
    .word_o (packed_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sign_q  <= 1'b0;
      ns_q    <= '0;
      ds_q    <= '0;
      ne_q    <= '0;
      de_q    <= '0;
      res_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (in_valid) begin
            sign_q <= n_sign;
            ns_q   <= n_sig;
            ds_q   <= d_sig;
            ne_q   <= n_exp;
            de_q   <= d_exp;
            if (nan_case) begin
              res_q   <= QNAN;
              state_q <= ST_DONE;
            end else if (pass_case) begin
              res_q   <= num_i;
              state_q <= ST_DONE;
            end else begin
              state_q <= ST_RUN;
            end
          end
        end
        ST_RUN: begin
          if (step_go) begin
            ns_q <= {diff[SW-2:0], 1'b0};
            ne_q <= ne_q - $signed(XW'(1));
          end else begin
            res_q   <= packed_w;
            state_q <= ST_DONE;
          end
        end
        ST_DONE: begin
          if (out_ready) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign in_ready  = (state_q == ST_IDLE);
  assign out_valid = (state_q == ST_DONE);
  assign res_o     = res_q;

  // loop-length counter used only by the bound check
  logic [CNT_W-1:0] run_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  run_cnt <= '0;
    else if (state_q == ST_RUN)  run_cnt <= run_cnt + 1'b1;
    else if (state_q == ST_IDLE) run_cnt <= '0;
  end

  // R8
  loop_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN) |-> (run_cnt < CNT_W'(MAX_RUN)));

  // R4
  sig_headroom_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN) |-> ({1'b0, ns_q} < {ds_q, 1'b0}));

  // R4
  sign_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (res_o != QNAN)) |-> (res_o[W-1] == sign_q));

  // R1
  nan_canon_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (res_o[W-2 -: EXP_W] == '1)) |-> (res_o == QNAN));

  // R6
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(res_o)));

  // R7
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> in_ready);

endmodule

// File: tb/fp_remainder_tb.sv
module fp_remainder_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] num = '0;
  logic [31:0] den = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] res;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  fp_remainder u_dut (
    .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_ready (in_ready),
    .num_i (num), .den_i (den), .out_valid (out_valid), .out_ready (out_ready),
    .res_o (res)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 195000) begin
      fails++;
      $display("FAIL watchdog: run hung, got cycle %0d expected < 195000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  function automatic logic [31:0] ref_rem(input logic [31:0] n, input logic [31:0] d);
    logic [7:0] fn, fd;
    logic [22:0] gn, gd;
    longint unsigned mn, md, r, dd;
    int en, ed, e;
    fn = n[30:23]; gn = n[22:0]; fd = d[30:23]; gd = d[22:0];
    if ((fn == 8'hFF) || (fd == 8'hFF && gd != 0) || (fd == 0 && gd == 0))
      return 32'h7FC00000;
    if ((fd == 8'hFF) || (fn == 0 && gn == 0))
      return n;
    mn = (fn == 0) ? longint'(gn) : (longint'(gn) | 64'h800000);
    md = (fd == 0) ? longint'(gd) : (longint'(gd) | 64'h800000);
    en = (fn == 0) ? -149 : int'(fn) - 150;
    ed = (fd == 0) ? -149 : int'(fd) - 150;
    if (ed > en) begin
      e = en;
      if (ed - en >= 25) r = mn;
      else begin
        dd = md << (ed - en);
        r  = mn % dd;
      end
    end else begin
      e = ed;
      r = mn % md;
      for (int k = 0; k < en - ed; k++) r = (2 * r) % md;
    end
    if (r == 0) return {n[31], 31'b0};
    while (r < 64'h800000 && e > -149) begin
      r = r << 1;
      e = e - 1;
    end
    if (r >= 64'h800000) return {n[31], 8'(e + 150), r[22:0]};
    return {n[31], 8'h00, r[22:0]};
  endfunction

  function automatic logic [31:0] pick(input int i);
    case (i)
      0: return 32'h00000000;  1: return 32'h80000000;
      2: return 32'h7F800000;  3: return 32'hFF800000;
      4: return 32'h7FC00000;  5: return 32'h7F800001;
      6: return 32'h3F800000;  7: return 32'h40400000;
      8: return 32'h3DCCCCCD;  9: return 32'h40F00000;
      10: return 32'h7F7FFFFF; 11: return 32'h00800000;
      12: return 32'h00000001; 13: return 32'h007FFFFF;
      14: return 32'h40C00000; 15: return 32'h41700000;
      16: return 32'h71800000; 17: return 32'h0D800000;
      18: return 32'hC0B00000; default: return 32'h3FC00000;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %08h expected %08h", tag, got, exp);
    end
  endtask

  task automatic apply(input logic [31:0] n, input logic [31:0] d,
                       output logic [31:0] r, output int lat);
    int w;
    w = 0;
    while (!in_ready && w < 400) begin @(negedge clk); w++; end
    num = n; den = d; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    lat = 1;
    while (!out_valid && lat < 400) begin @(negedge clk); lat++; end
    r = res;
    if (!out_valid) r = 32'hDEADBEEF;
    @(negedge clk);
  endtask

  task automatic run_vec(input logic [31:0] n, input logic [31:0] d);
    logic [31:0] got, exp;
    int lat;
    string tag;
    apply(n, d, got, lat);
    exp = ref_rem(n, d);
    if (exp == 32'h7FC00000) tag = "R1";
    else if (d[30:23] == 8'hFF || n[30:0] == 0) tag = "R2";
    else if (n[30:0] < d[30:0]) tag = "R3";
    else if (n[30:23] == 0 || d[30:23] == 0 || exp[30:23] == 0) tag = "R5";
    else tag = "R4";
    check(tag, got, exp);
    if (lat > 280) check("R8 latency", 32'(lat), 32'd280);
  endtask

  initial begin
    logic [31:0] got, hold;
    int lat;
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 in_ready", {31'b0, in_ready}, 32'd1);
    check("R9 out_valid", {31'b0, out_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // directed cases named by requirement
    run_vec(32'h41700000, 32'h40C00000);          // R4 15 mod 6 = 3
    check("R4 15mod6", ref_rem(32'h41700000, 32'h40C00000), 32'h40400000);
    run_vec(32'hC0F00000, 32'h40000000);          // R4 -7.5 mod 2 = -1.5
    check("R4 neg", ref_rem(32'hC0F00000, 32'h40000000), 32'hBFC00000);
    run_vec(32'hC0C00000, 32'h40400000);          // R4 -6 mod 3 = -0
    check("R4 negzero", ref_rem(32'hC0C00000, 32'h40400000), 32'h80000000);

    // sweep over a table of special and ordinary values (R1, R2, R3, R4, R5)
    for (int i = 0; i < 20; i++)
      for (int j = 0; j < 20; j++)
        run_vec(pick(i), pick(j));

    // R4 dense normal sweep
    for (int ei = 0; ei < 4; ei++)
      for (int mi = 0; mi < 8; mi++)
        for (int ek = 0; ek < 4; ek++)
          for (int mk = 0; mk < 8; mk++)
            run_vec({mi[0], 8'(124 + ei * 3), mi[2:0], 20'hA5A5A},
                    {mk[1], 8'(122 + ek * 2), mk[2:0], 20'h3C3C3});

    // R5 subnormal sweep, both numerator classes
    for (int i = 0; i < 16; i++)
      for (int j = 0; j < 16; j++)
        run_vec({i[0], 7'h00, i[3], 23'(i * 32'h04D3A1 + 1)},
                {1'b0, 8'h00, 23'(j * 32'h01F7B + 3)});

    // R8 worst-case loop length
    apply(32'h7F7FFFFF, 32'h00000001, got, lat);
    check("R8 worst result", got, 32'h00000000);
    if (lat > 280) check("R8 worst latency", 32'(lat), 32'd280);
    else check("R8 worst latency", 32'd0, 32'd0);

    // R6: in_valid while busy is ignored
    num = 32'h7F7FFFFF; den = 32'h00000003; in_valid = 1'b1;
    @(negedge clk);
    num = 32'h3F800000; den = 32'h3F800000;
    for (int k = 0; k < 6; k++) begin
      check("R6 in_ready busy", {31'b0, in_ready}, 32'd0);
      @(negedge clk);
    end
    in_valid = 1'b0;
    lat = 0;
    while (!out_valid && lat < 400) begin @(negedge clk); lat++; end
    check("R6 pending result", res, ref_rem(32'h7F7FFFFF, 32'h00000003));
    @(negedge clk);

    // R7: back-pressure holds the result
    out_ready = 1'b0;
    num = 32'h40F00000; den = 32'h40000000; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    lat = 0;
    while (!out_valid && lat < 400) begin @(negedge clk); lat++; end
    hold = res;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check("R7 valid held", {31'b0, out_valid}, 32'd1);
      check("R7 data held", res, hold);
      check("R6 not ready", {31'b0, in_ready}, 32'd0);
    end
    check("R7 value", hold, 32'h3FC00000);
    out_ready = 1'b1;
    @(negedge clk);
    check("R7 released", {31'b0, out_valid}, 32'd0);
    check("R7 ready again", {31'b0, in_ready}, 32'd1);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule